// File: doc/BRIEF.md
# TDM Time-Slot Route Sequencer

This block splits one serial TDM line into time slots and sends each slot to one serial channel. It keeps two small route tables, one for the receive direction and one for the transmit direction. Each direction runs on its own line clock and starts a new frame on its own sync pulse. A table entry gives four things: a channel code, a run length, four strobe levels and a pin-swap flag. Each direction walks its table entry by entry. For each slot, the receive side raises a valid flag for the selected channel along with the sampled bit. The transmit side takes the bit from the selected channel and drives it on the transmit pin. Slots that are not routed to a channel leave the transmit pin undriven.

Software fills the tables through a write-only register port while the sequencer is disabled. A route word has this layout:

| Bits | Field |
|------|-------|
| [15] | last-entry flag |
| [14] | unit select: 0 = bit, 1 = byte |
| [13:11] | count |
| [10:7] | channel code |
| [6] | ignored |
| [5:2] | strobe levels |
| [1] | pin swap |
| [0] | ignored |

The four strobe outputs let external parts find their own slots.

All timing is counted from the edge that samples sync high. Bit period k is the span between the k-th and (k+1)-th edges after that edge, with k starting at 0. A receive bit is sampled at the edge that closes its period. From that edge it is shown on `rx_valid`/`rx_data` for one period.

Top module: `tdm_slot_router`

## Requirements
- R1: An entry lasts (count+1) units. A unit is 1 bit when word bit [14] is 0 and 8 bits when it is 1. Count 0 gives 1 unit and count 7 gives 8 units.
- R2: Channel codes map to `rx_valid`/`tx_take` bits as follows: codes 1 to 6 select bits 0 to 5, and codes 9 to 11 select bits 6 to 8. During a receive slot of a mapped code, exactly that `rx_valid` bit is high for the period after the sampling edge, and `rx_data` holds the sampled bit. At all other times `rx_valid` is zero and `rx_data` is 0.
- R3: Channel codes 0, 7, 8 and 12 to 15 route nowhere. In such a transmit slot, neither data pin is driven and no `tx_take` bit is set. In such a receive slot, no `rx_valid` bit is raised.
- R4: Each strobe output is the OR of two registered values: the current receive entry's strobe bit and the current transmit entry's strobe bit. A strobe set in two consecutive entries stays high with no gap between them. A strobe is low whenever neither direction is inside a frame.
- R5: The swap flag applies only to receive-table entries. While a receive entry with the flag set is current, three things change. The receive bit is sampled from `txd_i`. The transmit bit is driven on `rxd_o` with `rxd_oe` high. `txd_oe` is low. The swap flag has no effect in transmit-table entries.
- R6: A frame ends after the entry that has the last flag or, failing that, after the final table location. After that the direction stays idle, with strobes low and pins undriven, until its next sync.
- R7: A sync sampled high while enabled restarts the direction at entry 0, even in mid-frame. A sync that arrives while a frame is still running sets that direction's frame error flag. The flag stays set until reset.
- R8: Table writes are accepted only while `seq_en` is low. A write made while `seq_en` is high leaves the table unchanged.
- R9: Word bits [0] and [6] have no effect on routing, run length or strobes.
- R10: After reset, all outputs are low and both tables hold zero.
- R11: Pulling `seq_en` low returns both directions to idle at the next edge of their line clocks. Strobes go low and the pins are released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Clock of the table write port |
| rx_clk | input | 1 | Receive line clock |
| tx_clk | input | 1 | Transmit line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_en | input | 1 | Sequencer enable; also blocks table writes |
| cfg_we | input | 1 | Table write strobe |
| cfg_tx_sel | input | 1 | Write target: 0 = receive table, 1 = transmit table |
| cfg_addr | input | AW | Table entry index |
| cfg_wdata | input | 16 | Route word |
| rx_sync | input | 1 | Receive frame sync |
| tx_sync | input | 1 | Transmit frame sync |
| rxd_i | input | 1 | Receive pin, input side |
| rxd_o | output | 1 | Receive pin, output side (used while swapped) |
| rxd_oe | output | 1 | Receive pin output enable |
| txd_i | input | 1 | Transmit pin, input side (used while swapped) |
| txd_o | output | 1 | Transmit pin, output side |
| txd_oe | output | 1 | Transmit pin output enable |
| rx_data | output | 1 | Routed receive bit |
| rx_valid | output | 9 | One-hot channel valid for `rx_data` |
| tx_data | input | 9 | Next transmit bit from each channel |
| tx_take | output | 9 | One-hot: channel whose bit is sent this period |
| strobe | output | 4 | Slot strobes |
| rx_frame_err | output | 1 | Sticky receive framing error |
| tx_frame_err | output | 1 | Sticky transmit framing error |

## Verification
The hardest case to reach from the ports is a receive entry with the swap flag that overlaps a live transmit slot. Here a bit crosses from the transmit table to the receive pin, and the transmit pin has to stay released. To reach it, the stimulus sends both syncs in the same cycle, so that a swapped receive entry lines up with a routed transmit entry. The transmit entry also carries its own swap flag, which must have no effect. The bench then counts the cycles in which each pin is driven. A second hard case is a sync in mid-frame. It is placed only after checks confirm that frames ending normally left the error flags clear.

// File: rtl/tsr_pkg.sv
`timescale 1ns/1ps
package tsr_pkg;

    localparam int NCH   = 9;
    localparam int WORDW = 16;
    localparam int NSTB  = 4;
    localparam int RUNW  = 6;

    typedef struct packed {
        logic            last;
        logic            byte_g;
        logic [2:0]      cnt;
        logic [3:0]      chan;
        logic [NSTB-1:0] strb;
        logic            swap;
    } entry_t;

    function automatic entry_t unpack_word(input logic [WORDW-1:0] w);
        entry_t e;
        e.last   = w[15];
        e.byte_g = w[14];
        e.cnt    = w[13:11];
        e.chan   = w[10:7];
        e.strb   = w[5:2];
        e.swap   = w[1];
        return e;
    endfunction

    function automatic logic [NCH-1:0] route_of(input logic [3:0] code);
        logic [NCH-1:0] r;
        r = '0;
        if (code >= 4'd1 && code <= 4'd6)
            r[int'(code) - 1] = 1'b1;
        else if (code >= 4'd9 && code <= 4'd11)
            r[int'(code) - 3] = 1'b1;
        return r;
    endfunction

    function automatic logic [RUNW-1:0] final_bit(input entry_t e);
        return e.byte_g ? {e.cnt, 3'b111} : {3'b000, e.cnt};
    endfunction

endpackage

// File: rtl/tsr_table.sv
`timescale 1ns/1ps
module tsr_table
    import tsr_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    cfg_clk,
    input  logic                    rst_n,
    input  logic                    seq_en,
    input  logic                    we,
    input  logic                    tx_sel,
    input  logic [AW-1:0]           addr,
    input  logic [WORDW-1:0]        wdata,
    output entry_t [DEPTH-1:0]      rx_tbl,
    output entry_t [DEPTH-1:0]      tx_tbl
);

    typedef struct packed {
        entry_t [DEPTH-1:0] rx;
        entry_t [DEPTH-1:0] tx;
    } tbl_t;

    tbl_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (we && !seq_en && (int'(addr) < DEPTH)) begin
            if (tx_sel) t_d.tx[addr] = unpack_word(wdata);
            else        t_d.rx[addr] = unpack_word(wdata);
        end
    end

    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign rx_tbl = t_q.rx;
    assign tx_tbl = t_q.tx;

    // R8
    locked_tbl_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        seq_en |=> $stable(t_q));

endmodule

// File: rtl/tsr_walker.sv
`timescale 1ns/1ps
module tsr_walker
    import tsr_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               sync,
    input  entry_t [DEPTH-1:0] tbl,
    output logic               active,
    output entry_t             cur,
    output logic [NSTB-1:0]    strb,
    output logic               err
);

    typedef struct packed {
        logic            active;
        logic [AW-1:0]   idx;
        logic [RUNW-1:0] left;
        logic [NSTB-1:0] strb;
        logic            err;
    } walk_t;

    walk_t s_d, s_q;
    entry_t now_e, nxt_e;
    logic [AW-1:0] nxt_idx;
    logic at_end;

    always_comb begin
        now_e   = tbl[s_q.idx];
        nxt_idx = s_q.idx + 1'b1;
        nxt_e   = tbl[nxt_idx];
        at_end  = now_e.last || (int'(s_q.idx) == DEPTH - 1);
        s_d     = s_q;
        if (!en) begin
            s_d.active = 1'b0;
            s_d.idx    = '0;
            s_d.left   = '0;
            s_d.strb   = '0;
        end else if (sync) begin
            s_d.err    = s_q.err | s_q.active;
            s_d.active = 1'b1;
            s_d.idx    = '0;
            s_d.left   = final_bit(tbl[0]);
            s_d.strb   = tbl[0].strb;
        end else if (s_q.active) begin
            if (s_q.left != '0) begin
                s_d.left = s_q.left - 1'b1;
            end else if (at_end) begin
                s_d.active = 1'b0;
                s_d.strb   = '0;
            end else begin
                s_d.idx  = nxt_idx;
                s_d.left = final_bit(nxt_e);
                s_d.strb = nxt_e.strb;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active = s_q.active;
    assign cur    = now_e;
    assign strb   = s_q.strb;
    assign err    = s_q.err;

    // R7
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.err |=> s_q.err);

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sync) |=> (s_q.active && s_q.idx == '0));

    // R1
    hold_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sync && s_q.active && s_q.left != '0) |=> (s_q.idx == $past(s_q.idx)));

    // R6
    idle_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.active |-> (s_q.strb == '0));

    // R11
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !s_q.active);

endmodule

// File: rtl/tdm_slot_router.sv
`timescale 1ns/1ps
module tdm_slot_router
    import tsr_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            cfg_clk,
    input  logic            rx_clk,
    input  logic            tx_clk,
    input  logic            rst_n,
    input  logic            seq_en,
    input  logic            cfg_we,
    input  logic            cfg_tx_sel,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [15:0]     cfg_wdata,
    input  logic            rx_sync,
    input  logic            tx_sync,
    input  logic            rxd_i,
    output logic            rxd_o,
    output logic            rxd_oe,
    input  logic            txd_i,
    output logic            txd_o,
    output logic            txd_oe,
    output logic            rx_data,
    output logic [8:0]      rx_valid,
    input  logic [8:0]      tx_data,
    output logic [8:0]      tx_take,
    output logic [3:0]      strobe,
    output logic            rx_frame_err,
    output logic            tx_frame_err
);

    entry_t [DEPTH-1:0] rx_tbl, tx_tbl;
    entry_t rx_cur, tx_cur;
    logic rx_act, tx_act;
    logic [NSTB-1:0] rx_strb, tx_strb;

    tsr_table #(.DEPTH(DEPTH)) u_table (
        .cfg_clk (cfg_clk),
        .rst_n   (rst_n),
        .seq_en  (seq_en),
        .we      (cfg_we),
        .tx_sel  (cfg_tx_sel),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rx_tbl  (rx_tbl),
        .tx_tbl  (tx_tbl)
    );

    tsr_walker #(.DEPTH(DEPTH)) u_rx_walk (
        .clk    (rx_clk),
        .rst_n  (rst_n),
        .en     (seq_en),
        .sync   (rx_sync),
        .tbl    (rx_tbl),
        .active (rx_act),
        .cur    (rx_cur),
        .strb   (rx_strb),
        .err    (rx_frame_err)
    );

    tsr_walker #(.DEPTH(DEPTH)) u_tx_walk (
        .clk    (tx_clk),
        .rst_n  (rst_n),
        .en     (seq_en),
        .sync   (tx_sync),
        .tbl    (tx_tbl),
        .active (tx_act),
        .cur    (tx_cur),
        .strb   (tx_strb),
        .err    (tx_frame_err)
    );

    // Receive routing register
    typedef struct packed {
        logic           data;
        logic [NCH-1:0] valid;
    } rxo_t;

    rxo_t r_d, r_q;

    always_comb begin
        r_d       = '0;
        if (rx_act) begin
            r_d.valid = route_of(rx_cur.chan);
            if (r_d.valid != '0)
                r_d.data = rx_cur.swap ? txd_i : rxd_i;
        end
    end

    always_ff @(posedge rx_clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_valid = r_q.valid;
    assign rx_data  = r_q.data;

    // Transmit selection and pin steering
    logic [NCH-1:0] tx_sel;
    logic tx_drive, tx_bit, swap_now;

    always_comb begin
        tx_sel   = tx_act ? route_of(tx_cur.chan) : '0;
        tx_drive = |tx_sel;
        tx_bit   = |(tx_sel & tx_data);
        swap_now = rx_act && rx_cur.swap;
    end

    assign tx_take = tx_sel;
    assign rxd_oe  = swap_now && tx_drive;
    assign rxd_o   = (swap_now && tx_drive) ? tx_bit : 1'b0;
    assign txd_oe  = !swap_now && tx_drive;
    assign txd_o   = (!swap_now && tx_drive) ? tx_bit : 1'b0;
    assign strobe  = rx_strb | tx_strb;

    // R2
    onehot_rx_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
        $onehot0(rx_valid));

    // R5
    pin_excl_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
        !(txd_oe && rxd_oe));

    // R3
    drive_needs_take_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
        (txd_oe || rxd_oe) |-> $onehot(tx_take));

endmodule

// File: tb/tdm_slot_router_test.sv
`timescale 1ns/1ps
module tdm_slot_router_test;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, seq_en, cfg_we, cfg_tx_sel;
    logic [2:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic        rx_sync, tx_sync, rxd_i, txd_i;
    logic [8:0]  tx_data;
    logic        rxd_o, rxd_oe, txd_o, txd_oe, rx_data;
    logic [8:0]  rx_valid, tx_take;
    logic [3:0]  strobe;
    logic        rx_frame_err, tx_frame_err;

    tdm_slot_router #(.DEPTH(8)) uut (
        .cfg_clk(clk), .rx_clk(clk), .tx_clk(clk), .rst_n(rst_n),
        .seq_en(seq_en), .cfg_we(cfg_we), .cfg_tx_sel(cfg_tx_sel),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rx_sync(rx_sync), .tx_sync(tx_sync),
        .rxd_i(rxd_i), .rxd_o(rxd_o), .rxd_oe(rxd_oe),
        .txd_i(txd_i), .txd_o(txd_o), .txd_oe(txd_oe),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_data(tx_data), .tx_take(tx_take), .strobe(strobe),
        .rx_frame_err(rx_frame_err), .tx_frame_err(tx_frame_err)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [15:0] rw [8];
    logic [15:0] tw [8];
    int rq[$];
    int tq[$];
    int rcur = -1;
    int tcur = -1;
    bit rerr = 1'b0, terr = 1'b0;
    logic [8:0] e_rv = '0;
    logic e_rd = 1'b0;

    function automatic int slot_of(input logic [15:0] w);
        int c = int'(w[10:7]);
        if (c >= 1 && c <= 6) return c - 1;
        if (c >= 9 && c <= 11) return c - 3;
        return -1;
    endfunction

    task automatic step_dir(input bit tx, input bit sy);
        logic [15:0] t [8];
        int q[$];
        int cur;
        bit er;
        for (int i = 0; i < 8; i++) t[i] = tx ? tw[i] : rw[i];
        q   = tx ? tq : rq;
        cur = tx ? tcur : rcur;
        er  = tx ? terr : rerr;
        if (!seq_en) begin
            q.delete();
            cur = -1;
        end else if (sy) begin
            if (cur >= 0) er = 1'b1;
            q.delete();
            for (int e = 0; e < 8; e++) begin
                int n = (int'(t[e][13:11]) + 1) * (t[e][14] ? 8 : 1);
                for (int k = 0; k < n; k++) q.push_back(e);
                if (t[e][15]) break;
            end
            cur = q.pop_front();
        end else if (cur >= 0) begin
            cur = (q.size() > 0) ? q.pop_front() : -1;
        end
        if (tx) begin tq = q; tcur = cur; terr = er; end
        else    begin rq = q; rcur = cur; rerr = er; end
    endtask

    always @(posedge clk) begin
        int s;
        if (!rst_n) begin
            rq.delete(); tq.delete();
            rcur = -1; tcur = -1; rerr = 0; terr = 0;
            e_rv = '0; e_rd = 0;
            for (int i = 0; i < 8; i++) begin rw[i] = '0; tw[i] = '0; end
        end else begin
            e_rv = '0; e_rd = 1'b0;
            if (rcur >= 0) begin
                s = slot_of(rw[rcur]);
                if (s >= 0) begin
                    e_rv[s] = 1'b1;
                    e_rd = rw[rcur][1] ? txd_i : rxd_i;
                end
            end
            step_dir(1'b0, rx_sync);
            step_dir(1'b1, tx_sync);
            if (cfg_we && !seq_en) begin
                if (cfg_tx_sel) tw[cfg_addr] = cfg_wdata;
                else            rw[cfg_addr] = cfg_wdata;
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    int vcnt[9];
    int tkcnt[9];
    int txoe_cnt = 0, rxoe_cnt = 0;

    always @(negedge clk) begin
        logic [3:0] e_stb;
        logic [8:0] e_take;
        bit swp, drv;
        logic tb;
        int ts;
        if (rst_n && !done) begin
            e_stb = '0;
            if (rcur >= 0) e_stb = e_stb | rw[rcur][5:2];
            if (tcur >= 0) e_stb = e_stb | tw[tcur][5:2];
            ts = (tcur >= 0) ? slot_of(tw[tcur]) : -1;
            drv = (ts >= 0);
            e_take = '0;
            tb = 1'b0;
            if (drv) begin e_take[ts] = 1'b1; tb = tx_data[ts]; end
            swp = (rcur >= 0) && rw[rcur][1];
            chk("R2 rx_valid", 32'(rx_valid), 32'(e_rv));
            chk("R2 rx_data", 32'(rx_data), 32'(e_rd));
            chk("R4 strobe", 32'(strobe), 32'(e_stb));
            chk("R3 tx_take", 32'(tx_take), 32'(e_take));
            chk("R3 txd_oe", 32'(txd_oe), 32'(drv && !swp));
            chk("R5 rxd_oe", 32'(rxd_oe), 32'(drv && swp));
            if (txd_oe) chk("R2 txd_o", 32'(txd_o), 32'(tb));
            if (rxd_oe) chk("R5 rxd_o", 32'(rxd_o), 32'(tb));
            chk("R7 rx_frame_err", 32'(rx_frame_err), 32'(rerr));
            chk("R7 tx_frame_err", 32'(tx_frame_err), 32'(terr));
            for (int i = 0; i < 9; i++) begin
                vcnt[i]  += int'(rx_valid[i]);
                tkcnt[i] += int'(tx_take[i]);
            end
            txoe_cnt += int'(txd_oe);
            rxoe_cnt += int'(rxd_oe);
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [15:0] mk(input bit last, input bit byt, input int cnt,
                                       input int chan, input int strb, input bit swap,
                                       input bit junk);
        logic [2:0] c3 = 3'(cnt);
        logic [3:0] ch = 4'(chan);
        logic [3:0] st = 4'(strb);
        return {last, byt, c3, ch, junk, st, swap, junk};
    endfunction

    task automatic tick();
        @(negedge clk);
        #1;
        rxd_i   = 1'($urandom);
        txd_i   = 1'($urandom);
        tx_data = 9'($urandom);
        rx_sync = 1'b0;
        tx_sync = 1'b0;
        cfg_we  = 1'b0;
    endtask

    task automatic wr(input bit tx, input int a, input logic [15:0] w);
        tick();
        cfg_we = 1'b1; cfg_tx_sel = tx; cfg_addr = 3'(a); cfg_wdata = w;
    endtask

    task automatic clr_counts();
        for (int i = 0; i < 9; i++) begin vcnt[i] = 0; tkcnt[i] = 0; end
        txoe_cnt = 0; rxoe_cnt = 0;
    endtask

    task automatic sync_both();
        tick();
        clr_counts();
        rx_sync = 1'b1; tx_sync = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        rst_n = 0; seq_en = 0; cfg_we = 0; cfg_tx_sel = 0; cfg_addr = '0; cfg_wdata = '0;
        rx_sync = 0; tx_sync = 0; rxd_i = 0; txd_i = 0; tx_data = '0;
        clr_counts();
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 rx_valid", 32'(rx_valid), 0);
        chk("R10 strobe", 32'(strobe), 0);
        chk("R10 pins", 32'({txd_oe, rxd_oe, txd_o, rxd_o}), 0);
        chk("R10 errs", 32'({rx_frame_err, tx_frame_err}), 0);
        #1 rst_n = 1;

        // Scenario A: bit and byte runs, adjacent strobes (R1, R2, R4)
        wr(0, 0, mk(0, 0, 2, 1, 4'b0001, 0, 0));
        wr(0, 1, mk(0, 1, 0, 9, 4'b0001, 0, 0));
        wr(0, 2, mk(1, 0, 1, 0, 4'b0100, 0, 0));
        wr(1, 0, mk(0, 0, 3, 2, 4'b1000, 0, 0));
        wr(1, 1, mk(1, 1, 1, 11, 4'b0010, 0, 0));
        tick(); seq_en = 1'b1;
        sync_both();
        idle(40);
        chk("R1 bit run ch0", 32'(vcnt[0]), 3);
        chk("R1 byte run ch6", 32'(vcnt[6]), 8);
        chk("R1 tx bit run ch1", 32'(tkcnt[1]), 4);
        chk("R1 tx byte run ch8", 32'(tkcnt[8]), 16);
        chk("R6 idle pins", 32'({txd_oe, rxd_oe}), 0);
        chk("R6 idle strobe", 32'(strobe), 0);
        chk("R7 no error on clean frames", 32'({rx_frame_err, tx_frame_err}), 0);

        // R8: write while enabled is dropped
        wr(0, 1, mk(1, 0, 0, 2, 4'b1111, 0, 0));
        sync_both();
        idle(40);
        chk("R8 ignored write ch1", 32'(vcnt[1]), 0);
        chk("R8 old entry kept ch6", 32'(vcnt[6]), 8);

        // Scenario B: unrouted codes, ignored bits 0 and 6 (R3, R9)
        tick(); seq_en = 1'b0;
        wr(0, 0, mk(0, 0, 1, 4, 4'b0010, 0, 1));
        wr(0, 1, mk(1, 0, 2, 7, 4'b0010, 0, 1));
        wr(1, 0, mk(0, 0, 1, 0, 4'b0001, 0, 1));
        wr(1, 1, mk(0, 0, 1, 7, 4'b0000, 0, 0));
        wr(1, 2, mk(0, 0, 1, 8, 4'b0100, 0, 0));
        wr(1, 3, mk(1, 0, 1, 12, 4'b0000, 0, 1));
        tick(); seq_en = 1'b1;
        sync_both();
        idle(20);
        chk("R9 run with bits 0/6 set", 32'(vcnt[3]), 2);
        chk("R3 unrouted tx never driven", 32'(txoe_cnt + rxoe_cnt), 0);
        chk("R3 unrouted rx no valid", 32'(vcnt[5] + vcnt[6] + vcnt[4]), 0);

        // Scenario C: swap in rx entry, swap ignored in tx entry (R5)
        tick(); seq_en = 1'b0;
        wr(0, 0, mk(0, 0, 3, 3, 4'b0000, 1, 0));
        wr(0, 1, mk(1, 0, 1, 5, 4'b0000, 0, 0));
        wr(1, 0, mk(1, 0, 5, 6, 4'b0000, 1, 0));
        tick(); seq_en = 1'b1;
        sync_both();
        idle(20);
        chk("R5 rx pin driven while swapped", 32'(rxoe_cnt), 4);
        chk("R5 tx pin driven after swap", 32'(txoe_cnt), 2);
        chk("R5 swapped slot still routed", 32'(vcnt[2]), 4);

        // Scenario D: no last flag, mid-frame sync (R6, R7)
        tick(); seq_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            wr(0, i, mk(0, 0, 0, 1, (i % 2 == 0) ? 4'b0001 : 4'b0011, 0, 0));
            wr(1, i, mk(0, 0, 1, 10, (i < 4) ? 4'b0100 : 4'b0000, 0, 0));
        end
        tick(); seq_en = 1'b1;
        sync_both();
        idle(30);
        chk("R6 frame ends at final location", 32'(vcnt[0]), 8);
        chk("R6 tx frame ends at final location", 32'(tkcnt[7]), 16);
        sync_both();
        idle(3);
        sync_both();
        idle(2);
        chk("R7 rx mid-frame error", 32'(rx_frame_err), 1);
        chk("R7 tx mid-frame error", 32'(tx_frame_err), 1);
        idle(30);
        sync_both();
        idle(30);
        chk("R7 error stays set", 32'({rx_frame_err, tx_frame_err}), 32'h3);

        // Scenario E: disable mid-frame (R11)
        sync_both();
        idle(4);
        tick(); seq_en = 1'b0;
        idle(2);
        chk("R11 strobe low after disable", 32'(strobe), 0);
        chk("R11 pins released", 32'({txd_oe, rxd_oe, rx_valid}), 0);
        idle(3);

        finish_run();
    end

endmodule